// File: doc/BRIEF.md
# Clock Synthesizer Control Register Target

This block is the serial control front end of a clock synthesizer. It behaves as a two-wire (I2C) target, holds the configuration registers that steer the loop, the feedback divider, the phase adjuster and the output stage, and reports the lock state of the loop and of the phase aligner. A host reaches any register with a write transfer, meaning a register index followed by data bytes. It reads a register by setting the index with a write and then issuing a repeated START with the read bit set. The index advances after every data byte, so bursts walk through neighbouring registers.

The loop-control register, both feedback-divider bytes and the phase-resolution register are held twice. A host write only changes a shadow copy, and the working copy that drives the synthesizer stays as it was. The host commits the shadows by writing a command byte to index 08h. The upper nibble of that byte commits the loop group and the lower nibble commits the phase group. The register positions are fixed because host software decodes them. SCL and SDA are sampled through a synchronizer on the system clock, and the target pulls SDA low through an open-drain enable.

Top module: `clksyn_ctl_regs`

## Requirements
- R1: The target answers only to the 7-bit address 010011X, where X is the level of `addr_sel`. The write/read address bytes are therefore 4Ch/4Dh when X=0 and 4Eh/4Fh when X=1. Any other address is not acknowledged, and the rest of that transfer changes no register.
- R2: A write transfer is START, address with R/W=0, index byte, data bytes, STOP. Every byte is MSB first and is acknowledged. The index increases by one after each data byte.
- R3: A read transfer uses a repeated START with R/W=1. The target sends register bytes MSB first, and the index increases after each byte. A host NACK ends the read.
- R4: After reset the registers hold the following values. Index 00h is 41h, 01h is 00h, 02h is FFh, 03h is 0Fh, 04h is 80h, 05h is 03h, 06h is 00h and 07h is 80h. The outputs show the same values.
- R5: Writes to indices 01h, 02h, 03h and 05h land in shadow copies, and a read returns the shadow. `loop_ctl_o`, `fb_div_o` and `phase_res_o` show the working copies, which do not change on such writes.
- R6: A write to index 08h whose bits 7:4 equal 5h copies the shadows of 01h-03h into the working copies. `fb_div_o` is {03h[3:0], 02h}.
- R7: A write to index 08h whose bits 3:0 equal Ah copies the shadow of 05h into its working copy, and 5Ah commits both groups. Any other nibble value commits nothing, and index 08h reads 00h.
- R8: Index 10h reads the version constant (18h by default) and index 11h reads the revision constant (01h by default). Writes to either index are ignored.
- R9: Index 12h reads `lock_phase` in bit 0 and `lock_loop` in bit 1, with bits 7:2 reading 0.
- R10: Reserved bits read 0 and never reach the outputs. These are bits 7:6 and 3 of 01h, bits 7:4 of 03h, bit 6 of 04h and bits 7:2 of 05h.
- R11: An index with no register is acknowledged. A read of it returns 00h, and a write to it changes nothing.
- R12: START and STOP are detected as SDA edges while SCL is high. A STOP in the middle of a byte abandons that byte with no write, and a later START begins a new address phase.
- R13: Indices 00h, 04h, 06h and 07h are single registers, and their outputs take the new value once the data byte is complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_drive_low | output | 1 | Open-drain enable: 1 pulls SDA low |
| addr_sel | input | 1 | Selects the low address bit of the target |
| lock_phase | input | 1 | Phase aligner locked |
| lock_loop | input | 1 | Loop locked |
| in_ctl_o | output | 8 | Input control register (00h) |
| loop_ctl_o | output | 8 | Working loop control (01h) |
| fb_div_o | output | 12 | Working feedback divider (03h[3:0], 02h) |
| phase_off_o | output | 8 | Phase offset and filter select (04h) |
| phase_res_o | output | 2 | Working phase resolution (05h[1:0]) |
| out_en_o | output | 8 | Output enables and scaler (06h) |
| osc_div_o | output | 8 | Oscillator divider and input select (07h) |

## Verification
The assertions assume that each SCL level lasts longer than the synchronizer latency plus one cycle, so every edge is seen exactly once. They also assume that SDA moves while SCL is high only to signal START or STOP. Under those conditions the commit checks can tie every change of a working copy to the command write one cycle earlier. The bench keeps each SCL phase at six system clocks and changes SDA only in the low phase, except when it forms START and STOP. Its host model also releases SDA during every acknowledge slot, so the target's drive is visible on the wired line.

// File: rtl/clksyn_ctl_pkg.sv
package clksyn_ctl_pkg;

   typedef enum logic [3:0] {
      ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_INDEX, ST_INDEX_ACK,
      ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RDATA_ACK
   } tgt_state_t;

   localparam logic [7:0] IDX_INPUT = 8'h00;
   localparam logic [7:0] IDX_PHOFF = 8'h04;
   localparam logic [7:0] IDX_OUTEN = 8'h06;
   localparam logic [7:0] IDX_OSC   = 8'h07;
   localparam logic [7:0] IDX_CMD   = 8'h08;
   localparam logic [7:0] IDX_VER   = 8'h10;
   localparam logic [7:0] IDX_REV   = 8'h11;
   localparam logic [7:0] IDX_LOCK  = 8'h12;

   localparam logic [7:0] RST_INPUT = 8'h41;
   localparam logic [7:0] RST_PHOFF = 8'h80;
   localparam logic [7:0] RST_OUTEN = 8'h00;
   localparam logic [7:0] RST_OSC   = 8'h80;
   localparam logic [7:0] MASK_PHOFF = 8'hBF;

   localparam logic [3:0] CMD_LOOP_NIB  = 4'h5;
   localparam logic [3:0] CMD_PHASE_NIB = 4'hA;

   // double-buffered registers: entry 0..3 = indices 01h, 02h, 03h, 05h
   localparam int DB_COUNT = 4;
   localparam logic [DB_COUNT-1:0][7:0] DB_IDX  = {8'h05, 8'h03, 8'h02, 8'h01};
   localparam logic [DB_COUNT-1:0][7:0] DB_MASK = {8'h03, 8'h0F, 8'hFF, 8'h37};
   localparam logic [DB_COUNT-1:0][7:0] DB_RST  = {8'h03, 8'h0F, 8'hFF, 8'h00};
   localparam logic [DB_COUNT-1:0]      DB_GRP_PHASE = 4'b1000;

endpackage

// File: rtl/clksyn_ctl_sync.sv
module clksyn_ctl_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_rise,
   output logic scl_fall,
   output logic sda_now,
   output logic start_det,
   output logic stop_det
);
   localparam int CHAIN_W = 2 * STAGES;

   logic [CHAIN_W-1:0] chain_q;
   logic               scl_p, sda_p;
   logic               scl_s, sda_s;

   generate
      if (STAGES == 2) begin : g_short
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[1:0], scl_in, sda_in};
      end else begin : g_long
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[CHAIN_W-3:0], scl_in, sda_in};
      end
   endgenerate

   assign scl_s = chain_q[CHAIN_W-1];
   assign sda_s = chain_q[CHAIN_W-2];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end

   assign scl_rise  = scl_s & ~scl_p;
   assign scl_fall  = ~scl_s & scl_p;
   assign sda_now   = sda_s;
   assign start_det = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/clksyn_ctl_tgt.sv
module clksyn_ctl_tgt
   import clksyn_ctl_pkg::*;
#(
   parameter logic [5:0] ADDR_HI = 6'b010011
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_rise,
   input  logic       scl_fall,
   input  logic       sda_now,
   input  logic       start_det,
   input  logic       stop_det,
   input  logic       addr_sel,
   input  logic [7:0] rd_data,
   output logic [7:0] rd_idx,
   output logic       wr_en,
   output logic [7:0] wr_idx,
   output logic [7:0] wr_data,
   output logic       sda_drive_low,
   output tgt_state_t state_o
);
   tgt_state_t state;
   logic [3:0] cnt;
   logic [7:0] sh, tx, idx;
   logic       rw, nack, drv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE; cnt <= '0; sh <= '0; tx <= '0; idx <= '0;
         rw <= 1'b0; nack <= 1'b0; drv <= 1'b0;
         wr_en <= 1'b0; wr_idx <= '0; wr_data <= '0;
      end else begin
         wr_en <= 1'b0;
         if (start_det) begin
            state <= ST_ADDR; cnt <= '0; drv <= 1'b0;
         end else if (stop_det) begin
            state <= ST_IDLE; drv <= 1'b0;
         end else begin
            if (scl_rise) begin
               case (state)
                  ST_ADDR, ST_INDEX, ST_WDATA: begin
                     sh  <= {sh[6:0], sda_now};
                     cnt <= cnt + 4'd1;
                  end
                  ST_RDATA:     cnt  <= cnt + 4'd1;
                  ST_RDATA_ACK: nack <= sda_now;
                  default: ;
               endcase
            end
            if (scl_fall) begin
               case (state)
                  ST_ADDR: if (cnt == 4'd8) begin
                     if (sh[7:1] == {ADDR_HI, addr_sel}) begin
                        rw <= sh[0]; drv <= 1'b1; state <= ST_ADDR_ACK;
                     end else state <= ST_IDLE;
                  end
                  ST_ADDR_ACK: begin
                     cnt <= '0;
                     if (rw) begin
                        tx <= rd_data; drv <= ~rd_data[7]; state <= ST_RDATA;
                     end else begin
                        drv <= 1'b0; state <= ST_INDEX;
                     end
                  end
                  ST_INDEX: if (cnt == 4'd8) begin
                     idx <= sh; drv <= 1'b1; state <= ST_INDEX_ACK;
                  end
                  ST_INDEX_ACK: begin
                     drv <= 1'b0; cnt <= '0; state <= ST_WDATA;
                  end
                  ST_WDATA: if (cnt == 4'd8) begin
                     wr_en <= 1'b1; wr_idx <= idx; wr_data <= sh;
                     idx <= idx + 8'd1; drv <= 1'b1; state <= ST_WDATA_ACK;
                  end
                  ST_WDATA_ACK: begin
                     drv <= 1'b0; cnt <= '0; state <= ST_WDATA;
                  end
                  ST_RDATA: if (cnt == 4'd8) begin
                     drv <= 1'b0; idx <= idx + 8'd1; state <= ST_RDATA_ACK;
                  end else begin
                     tx <= {tx[6:0], 1'b0}; drv <= ~tx[6];
                  end
                  ST_RDATA_ACK: if (nack) state <= ST_IDLE;
                  else begin
                     cnt <= '0; tx <= rd_data; drv <= ~rd_data[7]; state <= ST_RDATA;
                  end
                  default: ;
               endcase
            end
         end
      end
   end

   assign rd_idx        = idx;
   assign sda_drive_low = drv;
   assign state_o       = state;
endmodule

// File: rtl/clksyn_ctl_dbuf.sv
module clksyn_ctl_dbuf #(
   parameter logic [7:0] MASK = 8'hFF,
   parameter logic [7:0] RST  = 8'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_stb,
   input  logic [7:0] wr_data,
   input  logic       commit,
   output logic [7:0] shadow_o,
   output logic [7:0] working_o
);
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         shadow_o  <= RST;
         working_o <= RST;
      end else begin
         if (wr_stb) shadow_o  <= wr_data & MASK;
         if (commit) working_o <= shadow_o;
      end
endmodule

// File: rtl/clksyn_ctl_bank.sv
module clksyn_ctl_bank
   import clksyn_ctl_pkg::*;
#(
   parameter logic [7:0] CHIP_VER = 8'h18,
   parameter logic [7:0] CHIP_REV = 8'h01
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [7:0]  wr_idx,
   input  logic [7:0]  wr_data,
   input  logic [7:0]  rd_idx,
   input  logic        lock_phase,
   input  logic        lock_loop,
   output logic [7:0]  rd_data,
   output logic [7:0]  in_ctl_o,
   output logic [7:0]  loop_ctl_o,
   output logic [11:0] fb_div_o,
   output logic [7:0]  phase_off_o,
   output logic [1:0]  phase_res_o,
   output logic [7:0]  out_en_o,
   output logic [7:0]  osc_div_o
);
   logic [7:0] db_sh [DB_COUNT];
   logic [7:0] db_wk [DB_COUNT];
   logic       cmd_wr, commit_loop, commit_phase;

   assign cmd_wr       = wr_en && (wr_idx == IDX_CMD);
   assign commit_loop  = cmd_wr && (wr_data[7:4] == CMD_LOOP_NIB);
   assign commit_phase = cmd_wr && (wr_data[3:0] == CMD_PHASE_NIB);

   for (genvar g = 0; g < DB_COUNT; g++) begin : g_db
      logic commit_g, stb_g;
      assign commit_g = DB_GRP_PHASE[g] ? commit_phase : commit_loop;
      assign stb_g    = wr_en && (wr_idx == DB_IDX[g]);
      clksyn_ctl_dbuf #(.MASK(DB_MASK[g]), .RST(DB_RST[g])) u_db (
         .clk(clk), .rst_n(rst_n), .wr_stb(stb_g), .wr_data(wr_data),
         .commit(commit_g), .shadow_o(db_sh[g]), .working_o(db_wk[g]));
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         in_ctl_o    <= RST_INPUT;
         phase_off_o <= RST_PHOFF;
         out_en_o    <= RST_OUTEN;
         osc_div_o   <= RST_OSC;
      end else if (wr_en) begin
         case (wr_idx)
            IDX_INPUT: in_ctl_o    <= wr_data;
            IDX_PHOFF: phase_off_o <= wr_data & MASK_PHOFF;
            IDX_OUTEN: out_en_o    <= wr_data;
            IDX_OSC:   osc_div_o   <= wr_data;
            default: ;
         endcase
      end

   always_comb begin
      rd_data = '0;
      case (rd_idx)
         IDX_INPUT: rd_data = in_ctl_o;
         IDX_PHOFF: rd_data = phase_off_o;
         IDX_OUTEN: rd_data = out_en_o;
         IDX_OSC:   rd_data = osc_div_o;
         IDX_VER:   rd_data = CHIP_VER;
         IDX_REV:   rd_data = CHIP_REV;
         IDX_LOCK:  rd_data = {6'b0, lock_loop, lock_phase};
         default: ;
      endcase
      for (int k = 0; k < DB_COUNT; k++)
         if (rd_idx == DB_IDX[k]) rd_data = db_sh[k];
   end

   assign loop_ctl_o  = db_wk[0];
   assign fb_div_o    = {db_wk[2][3:0], db_wk[1]};
   assign phase_res_o = db_wk[3][1:0];
endmodule

// File: rtl/clksyn_ctl_regs.sv
module clksyn_ctl_regs
   import clksyn_ctl_pkg::*;
#(
   parameter logic [7:0] CHIP_VER    = 8'h18,
   parameter logic [7:0] CHIP_REV    = 8'h01,
   parameter logic [5:0] ADDR_HI     = 6'b010011,
   parameter int         SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        scl_in,
   input  logic        sda_in,
   output logic        sda_drive_low,
   input  logic        addr_sel,
   input  logic        lock_phase,
   input  logic        lock_loop,
   output logic [7:0]  in_ctl_o,
   output logic [7:0]  loop_ctl_o,
   output logic [11:0] fb_div_o,
   output logic [7:0]  phase_off_o,
   output logic [1:0]  phase_res_o,
   output logic [7:0]  out_en_o,
   output logic [7:0]  osc_div_o
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic       scl_rise, scl_fall, sda_now, start_det, stop_det;
   logic       wr_en;
   logic [7:0] wr_idx, wr_data, rd_idx, rd_data;
   tgt_state_t tgt_state;

   clksyn_ctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_now(sda_now),
      .start_det(start_det), .stop_det(stop_det));

   clksyn_ctl_tgt #(.ADDR_HI(ADDR_HI)) u_tgt (
      .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .sda_now(sda_now), .start_det(start_det), .stop_det(stop_det),
      .addr_sel(addr_sel), .rd_data(rd_data), .rd_idx(rd_idx),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .sda_drive_low(sda_drive_low), .state_o(tgt_state));

   clksyn_ctl_bank #(.CHIP_VER(CHIP_VER), .CHIP_REV(CHIP_REV)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .rd_idx(rd_idx), .lock_phase(lock_phase),
      .lock_loop(lock_loop), .rd_data(rd_data), .in_ctl_o(in_ctl_o),
      .loop_ctl_o(loop_ctl_o), .fb_div_o(fb_div_o), .phase_off_o(phase_off_o),
      .phase_res_o(phase_res_o), .out_en_o(out_en_o), .osc_div_o(osc_div_o));
endmodule

// File: rtl/clksyn_ctl_chk.sv
module clksyn_ctl_chk
   import clksyn_ctl_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input tgt_state_t  state,
   input logic        start_det,
   input logic        sda_drive_low,
   input logic        wr_en,
   input logic [7:0]  wr_idx,
   input logic [7:0]  wr_data,
   input logic [7:0]  loop_ctl_o,
   input logic [11:0] fb_div_o,
   input logic [1:0]  phase_res_o,
   input logic [7:0]  phase_off_o
);
   // R6: loop-group working copies move only after a loop commit command
   a_r6_loop_commit_only: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(loop_ctl_o) || !$stable(fb_div_o)) |->
      $past(wr_en && wr_idx == 8'h08 && wr_data[7:4] == 4'h5));

   // R7: phase working copy moves only after a phase commit command
   a_r7_phase_commit_only: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(phase_res_o) |->
      $past(wr_en && wr_idx == 8'h08 && wr_data[3:0] == 4'hA));

   // R10: reserved bits never reach the outputs
   a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ((loop_ctl_o & 8'hC8) == 8'h00) && (phase_off_o[6] == 1'b0));

   // R12: a START always begins a fresh address phase
   a_r12_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (state == ST_ADDR));

   // R3: SDA is pulled only in acknowledge or read-data phases
   a_r3_drive_phase: assert property (@(posedge clk) disable iff (!rst_n)
      sda_drive_low |-> (state == ST_ADDR_ACK || state == ST_INDEX_ACK ||
                         state == ST_WDATA_ACK || state == ST_RDATA));

   // R2: register writes come only out of a data byte
   a_r2_write_from_data: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (state == ST_WDATA_ACK));
endmodule

bind clksyn_ctl_regs clksyn_ctl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .state(tgt_state), .start_det(start_det),
   .sda_drive_low(sda_drive_low), .wr_en(wr_en), .wr_idx(wr_idx),
   .wr_data(wr_data), .loop_ctl_o(loop_ctl_o), .fb_div_o(fb_div_o),
   .phase_res_o(phase_res_o), .phase_off_o(phase_off_o));

// File: tb/clksyn_ctl_regs_test.sv
module clksyn_ctl_regs_test;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n = 1'b0;
   logic scl_h = 1'b1, sda_h = 1'b1;
   logic addr_sel = 1'b0, lock_phase = 1'b0, lock_loop = 1'b0;
   logic        sda_drive_low;
   logic [7:0]  in_ctl_o, loop_ctl_o, phase_off_o, out_en_o, osc_div_o;
   logic [11:0] fb_div_o;
   logic [1:0]  phase_res_o;
   wire         sda_line = sda_h & ~sda_drive_low;

   clksyn_ctl_regs uut (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_h), .sda_in(sda_line),
      .sda_drive_low(sda_drive_low), .addr_sel(addr_sel),
      .lock_phase(lock_phase), .lock_loop(lock_loop), .in_ctl_o(in_ctl_o),
      .loop_ctl_o(loop_ctl_o), .fb_div_o(fb_div_o), .phase_off_o(phase_off_o),
      .phase_res_o(phase_res_o), .out_en_o(out_en_o), .osc_div_o(osc_div_o));

   int errors = 0, checks = 0;
   localparam int Q = 6;

   // vector: index, byte written, byte expected on readback
   localparam int NV = 13;
   localparam logic [NV-1:0][23:0] VEC = {
      24'h09_66_00, 24'h2B_77_00, 24'h12_FF_00, 24'h11_55_01, 24'h10_00_18,
      24'h07_7E_7E, 24'h06_3C_3C, 24'h05_02_02, 24'h04_FF_BF, 24'h03_FF_0F,
      24'h02_12_12, 24'h01_FF_37, 24'h00_A5_A5};

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wq();
      repeat (Q) @(posedge clk);
      #1;
   endtask

   task automatic bit_out(input logic b);
      sda_h = b; wq(); scl_h = 1'b1; wq(); scl_h = 1'b0; wq();
   endtask

   task automatic bit_in(output logic b);
      sda_h = 1'b1; wq(); scl_h = 1'b1; wq(); b = sda_line; scl_h = 1'b0; wq();
   endtask

   task automatic bus_start();
      sda_h = 1'b1; wq(); scl_h = 1'b1; wq(); sda_h = 1'b0; wq(); scl_h = 1'b0; wq();
   endtask

   task automatic bus_stop();
      sda_h = 1'b0; wq(); scl_h = 1'b1; wq(); sda_h = 1'b1; wq();
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      logic a;
      for (int i = 7; i >= 0; i--) bit_out(b[i]);
      bit_in(a);
      ack = ~a;
   endtask

   task automatic recv_byte(input logic last, output logic [7:0] b);
      for (int i = 7; i >= 0; i--) bit_in(b[i]);
      bit_out(last);
   endtask

   function automatic logic [7:0] abyte(input logic rd);
      return {6'b010011, addr_sel, rd};
   endfunction

   task automatic write_raw(input logic [7:0] a, input logic [7:0] idx,
                            input logic [7:0] d, output logic ack);
      logic a1, a2, a3;
      bus_start(); send_byte(a, a1); send_byte(idx, a2); send_byte(d, a3); bus_stop();
      ack = a1 & a2 & a3;
   endtask

   task automatic write_reg(input logic [7:0] idx, input logic [7:0] d);
      logic ack;
      write_raw(abyte(1'b0), idx, d, ack);
      chk("R2 write acknowledged", {15'b0, ack}, 16'h1);
   endtask

   task automatic read_reg(input logic [7:0] idx, output logic [7:0] d);
      logic a;
      bus_start(); send_byte(abyte(1'b0), a); send_byte(idx, a);
      bus_start(); send_byte(abyte(1'b1), a); recv_byte(1'b1, d); bus_stop();
   endtask

   task automatic sample();
      @(negedge clk);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog all requirements actual=timeout expected=done");
      summary();
      $finish;
   end

   initial begin
      logic [7:0] d, d2, d3;
      logic       a;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      repeat (4) @(posedge clk);
      sample();
      // R4 reset state
      chk("R4 in_ctl reset",  {8'h0, in_ctl_o},    16'h0041);
      chk("R4 loop reset",    {8'h0, loop_ctl_o},  16'h0000);
      chk("R4 fbdiv reset",   {4'h0, fb_div_o},    16'h0FFF);
      chk("R4 phoff reset",   {8'h0, phase_off_o}, 16'h0080);
      chk("R4 phres reset",   {14'h0, phase_res_o}, 16'h0003);
      chk("R4 outen reset",   {8'h0, out_en_o},    16'h0000);
      chk("R4 osc reset",     {8'h0, osc_div_o},   16'h0080);
      chk("R12 sda released", {15'h0, sda_drive_low}, 16'h0);
      read_reg(8'h00, d); chk("R4 reg00 readback", {8'h0, d}, 16'h0041);
      read_reg(8'h05, d); chk("R4 reg05 readback", {8'h0, d}, 16'h0003);

      // table of single writes and readbacks (R5 R8 R10 R11 R13)
      for (int v = 0; v < NV; v++) begin
         write_reg(VEC[v][23:16], VEC[v][15:8]);
         read_reg(VEC[v][23:16], d);
         chk($sformatf("R5/R8/R10/R11 readback idx %h", VEC[v][23:16]),
             {8'h0, d}, {8'h0, VEC[v][7:0]});
      end
      sample();
      chk("R5 loop working unchanged",  {8'h0, loop_ctl_o},   16'h0000);
      chk("R5 fbdiv working unchanged", {4'h0, fb_div_o},     16'h0FFF);
      chk("R5 phres working unchanged", {14'h0, phase_res_o}, 16'h0003);
      chk("R13 in_ctl direct",  {8'h0, in_ctl_o},    16'h00A5);
      chk("R10 phoff masked",   {8'h0, phase_off_o}, 16'h00BF);
      chk("R13 outen direct",   {8'h0, out_en_o},    16'h003C);
      chk("R13 osc direct",     {8'h0, osc_div_o},   16'h007E);

      // R6 loop commit only
      write_reg(8'h08, 8'h5C); sample();
      chk("R6 loop committed",  {8'h0, loop_ctl_o},   16'h0037);
      chk("R6 fbdiv committed", {4'h0, fb_div_o},     16'h0F12);
      chk("R7 phase not committed by C", {14'h0, phase_res_o}, 16'h0003);
      // R7 phase commit only
      write_reg(8'h08, 8'h3A); sample();
      chk("R7 phase committed", {14'h0, phase_res_o}, 16'h0002);
      chk("R7 loop untouched by 3", {8'h0, loop_ctl_o}, 16'h0037);
      read_reg(8'h08, d); chk("R7 cmd reads zero", {8'h0, d}, 16'h0000);
      // R7 no-load nibbles
      write_reg(8'h02, 8'h99);
      write_reg(8'h08, 8'h4B); sample();
      chk("R7 no load on 4B", {4'h0, fb_div_o}, 16'h0F12);
      // R7 both groups
      write_reg(8'h01, 8'h05); write_reg(8'h05, 8'h01);
      write_reg(8'h08, 8'h5A); sample();
      chk("R7 5A loop",  {8'h0, loop_ctl_o},   16'h0005);
      chk("R7 5A fbdiv", {4'h0, fb_div_o},     16'h0F99);
      chk("R7 5A phase", {14'h0, phase_res_o}, 16'h0001);

      // R2 sequential write 06h,07h,08h
      bus_start(); send_byte(abyte(1'b0), a); send_byte(8'h06, a);
      send_byte(8'h11, a); send_byte(8'h22, a); send_byte(8'h33, a); bus_stop();
      sample();
      chk("R2 burst reg06", {8'h0, out_en_o},  16'h0011);
      chk("R2 burst reg07", {8'h0, osc_div_o}, 16'h0022);
      chk("R2 burst 33 no commit", {8'h0, loop_ctl_o}, 16'h0005);
      // R3 sequential read 06h,07h,08h
      bus_start(); send_byte(abyte(1'b0), a); send_byte(8'h06, a);
      bus_start(); send_byte(abyte(1'b1), a);
      recv_byte(1'b0, d); recv_byte(1'b0, d2); recv_byte(1'b1, d3); bus_stop();
      chk("R3 burst read 06", {8'h0, d},  16'h0011);
      chk("R3 burst read 07", {8'h0, d2}, 16'h0022);
      chk("R3 burst read 08", {8'h0, d3}, 16'h0000);

      // R9 lock status
      lock_loop = 1'b1; lock_phase = 1'b0;
      read_reg(8'h12, d); chk("R9 loop lock bit1", {8'h0, d}, 16'h0002);
      lock_loop = 1'b0; lock_phase = 1'b1;
      read_reg(8'h12, d); chk("R9 phase lock bit0", {8'h0, d}, 16'h0001);

      // R1 address selection
      addr_sel = 1'b1;
      write_raw(8'h4C, 8'h06, 8'hEE, a); sample();
      chk("R1 wrong address no ack", {15'h0, a}, 16'h0);
      chk("R1 wrong address ignored", {8'h0, out_en_o}, 16'h0011);
      write_raw(8'h4E, 8'h06, 8'h5D, a); sample();
      chk("R1 pin-high address ack", {15'h0, a}, 16'h1);
      chk("R1 pin-high write lands", {8'h0, out_en_o}, 16'h005D);
      read_reg(8'h06, d); chk("R1 read via 4Fh", {8'h0, d}, 16'h005D);
      addr_sel = 1'b0;

      // R12 STOP mid-byte abandons the write
      bus_start(); send_byte(abyte(1'b0), a); send_byte(8'h00, a);
      bit_out(1'b1); bit_out(1'b1); bit_out(1'b1); bit_out(1'b1);
      bus_stop(); sample();
      chk("R12 partial byte ignored", {8'h0, in_ctl_o}, 16'h00A5);
      write_reg(8'h00, 8'h3C); sample();
      chk("R12 recovers after stop", {8'h0, in_ctl_o}, 16'h003C);

      summary();
      $finish;
   end
endmodule